// File: doc/BRIEF.md
# Task switch validity sequencer

This block decides whether a protected-mode task switch may complete. The surrounding logic has already walked the descriptor tables. It presents a decoded snapshot of the incoming task on the input ports: the task-state descriptor's presence, busy marking and limit; the validity and presence of the local descriptor table; the code and stack selectors with their descriptor fields; and the four data segment selectors with validity, readable, present, conforming and DPL per segment. A single-cycle start pulse captures that snapshot, so the inputs may change freely once the pulse has been taken.

The sequencer then performs sixteen tests, one per clock, in a fixed priority order. After the third test, one extra cycle marks the point where the incoming register state counts as loaded. The first failing test ends the run. It reports a fault class and the selector to use as the error code. If every test passes, the run reports success, the new privilege level (taken from the requested privilege of the incoming code selector) and a one-clock pulse that sets the task-switched flag. In every case the done output pulses for exactly one clock.

Top module: `tsv_top`

## Requirements
- R1: Tests run one per clock after the start edge. Test k (1 to 3) fails with done high k cycles after the start edge, test k (4 to 16) fails k+1 cycles after it because of the load cycle, and a full pass signals done 17 cycles after it.
- R2: Task-state tests report the incoming task-state selector. If the descriptor is absent, the class is not-present. If it is marked busy, the class is general protection. If the limit is below MIN_TSS_LIMIT (103 by default, with 103 itself passing), the class is invalid-TSS.
- R3: An invalid LDT selector (test 4) or an absent LDT (test 5) reports invalid-TSS with the task-state selector.
- R4: Code segment tests report the code selector. An invalid selector (test 6) gives invalid-TSS. An absent segment (test 7) gives not-present. A DPL that differs from the code selector's RPL (test 8) gives invalid-TSS.
- R5: Stack tests report the stack selector. An invalid selector (test 9) gives general protection. An absent segment (test 10) gives stack fault. A DPL that differs from the new CPL (test 11) gives stack fault. A selector RPL that differs from the new CPL (test 12) gives general protection.
- R6: Data segment tests apply to DS, ES, FS and GS. Lane i sits at dataSel[16*i+15:16*i], and the per-lane bits sit at bit i (DPL at bits 2i+1:2i). The tests are: invalid selector (test 13, general protection), not readable (test 14, general protection), absent (test 15, not-present) and DPL below the new CPL (test 16, general protection). Within one test the lowest lane wins, and an earlier test wins over any lane order. The error code is the offending lane's selector.
- R7: A data selector whose bits 15:2 are all zero passes all four data tests. A lane marked conforming is exempt from test 16.
- R8: Only the first failing test in priority order is reported. The fault class encoding is 0 not-present, 1 general protection, 2 invalid-TSS, 3 stack fault.
- R9: On success, newCpl equals bits 1:0 of the captured code selector, and setTaskSwitched pulses in the same cycle as done. It never pulses on a fault.
- R10: A start pulse while busy is high is ignored and is not queued. The snapshot is captured only at an accepted start.
- R11: After reset, busy, done, pass, fault and setTaskSwitched are low.
- R12: done lasts one clock, with exactly one of pass or fault high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a check run and capture the snapshot |
| tssSel | input | 16 | Incoming task-state selector |
| tssPresent | input | 1 | Task-state descriptor present |
| tssBusy | input | 1 | Task-state descriptor marked busy |
| tssLimit | input | 32 | Task-state segment limit |
| ldtSelValid | input | 1 | LDT selector valid |
| ldtPresent | input | 1 | LDT present |
| csSel | input | 16 | Incoming code selector |
| csSelValid | input | 1 | Code selector valid |
| csPresent | input | 1 | Code segment present |
| csDpl | input | 2 | Code segment DPL |
| ssSel | input | 16 | Incoming stack selector |
| ssSelValid | input | 1 | Stack selector valid |
| ssPresent | input | 1 | Stack segment present |
| ssDpl | input | 2 | Stack segment DPL |
| dataSel | input | 64 | DS, ES, FS, GS selectors, lane 0 lowest |
| dataSelValid | input | 4 | Per-lane selector valid |
| dataReadable | input | 4 | Per-lane segment readable |
| dataPresent | input | 4 | Per-lane segment present |
| dataConforming | input | 4 | Per-lane conforming segment |
| dataDpl | input | 8 | Per-lane DPL, two bits each |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock end-of-run pulse |
| pass | output | 1 | Run succeeded (with done) |
| fault | output | 1 | Run failed (with done) |
| faultClass | output | 2 | Fault class code |
| errSel | output | 16 | Error-code selector |
| newCpl | output | 2 | Privilege level of the incoming task |
| setTaskSwitched | output | 1 | Pulse that sets the task-switched flag |

## Verification
Each of the sixteen tests is broken on its own. The bench then checks the class, the error selector and the exact done cycle. A design that forgot the load cycle, or reordered tests, would be late or early by a cycle, or would name the wrong test. Runs with several faults at once check priority: across tests, and across data lanes within one test. A design that scanned lanes before tests would report a later test. Null data selectors, conforming lanes with low DPL and a limit of exactly 103 must all pass; an off-by-one limit compare or a missing exemption would fault there. A second start while busy, with a broken snapshot presented, must leave the first run's result untouched, which exposes a design that re-captures or restarts.

// File: rtl/tsv_pkg.sv
package tsv_pkg;
  localparam int NUM_STAGES = 17;
  localparam int STAGE_W = $clog2(NUM_STAGES);
  localparam int LOAD_STAGE = 3;

  typedef enum logic [1:0] {
    FC_NOT_PRESENT = 2'd0,
    FC_GEN_PROT    = 2'd1,
    FC_BAD_TSS     = 2'd2,
    FC_STACK       = 2'd3
  } faultClass_e;

  typedef struct packed {
    logic               capture;
    logic               report;
    logic [STAGE_W-1:0] stage;
  } tsvStrobe_t;
endpackage

// File: rtl/tsv_ctrl.sv
module tsv_ctrl
  import tsv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       checkFail,
  output tsvStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       pass,
  output logic       fault,
  output logic       setTaskSwitched
);
  logic [STAGE_W-1:0] stage;
  logic accept;
  logic lastStage;
  logic report;

  assign accept    = start & ~busy;
  assign lastStage = (stage == STAGE_W'(NUM_STAGES - 1));
  assign report    = busy & (checkFail | lastStage);

  assign strobe.capture = accept;
  assign strobe.report  = report;
  assign strobe.stage   = stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy            <= 1'b0;
      stage           <= '0;
      done            <= 1'b0;
      pass            <= 1'b0;
      fault           <= 1'b0;
      setTaskSwitched <= 1'b0;
    end else begin
      done            <= report;
      pass            <= report & ~checkFail;
      fault           <= report & checkFail;
      setTaskSwitched <= report & ~checkFail;
      if (accept) begin
        busy  <= 1'b1;
        stage <= '0;
      end else if (busy) begin
        if (report) busy <= 1'b0;
        else        stage <= stage + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsv_dpath.sv
module tsv_dpath
  import tsv_pkg::*;
#(
  parameter int SEL_W         = 16,
  parameter int LIMIT_W       = 32,
  parameter int MIN_TSS_LIMIT = 103,
  parameter int NUM_DATA      = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  tsvStrobe_t                strobe,
  input  logic [SEL_W-1:0]          tssSel,
  input  logic                      tssPresent,
  input  logic                      tssBusy,
  input  logic [LIMIT_W-1:0]        tssLimit,
  input  logic                      ldtSelValid,
  input  logic                      ldtPresent,
  input  logic [SEL_W-1:0]          csSel,
  input  logic                      csSelValid,
  input  logic                      csPresent,
  input  logic [1:0]                csDpl,
  input  logic [SEL_W-1:0]          ssSel,
  input  logic                      ssSelValid,
  input  logic                      ssPresent,
  input  logic [1:0]                ssDpl,
  input  logic [NUM_DATA*SEL_W-1:0] dataSel,
  input  logic [NUM_DATA-1:0]       dataSelValid,
  input  logic [NUM_DATA-1:0]       dataReadable,
  input  logic [NUM_DATA-1:0]       dataPresent,
  input  logic [NUM_DATA-1:0]       dataConforming,
  input  logic [2*NUM_DATA-1:0]     dataDpl,
  output logic                      checkFail,
  output logic [1:0]                faultClass,
  output logic [SEL_W-1:0]          errSel,
  output logic [1:0]                newCpl
);
  localparam int DIDX_W = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1;

  logic [SEL_W-1:0]          capTssSel, capCsSel, capSsSel;
  logic                      capTssPresent, capTssBusy, capLdtValid, capLdtPresent;
  logic [LIMIT_W-1:0]        capLimit;
  logic                      capCsValid, capCsPresent, capSsValid, capSsPresent;
  logic [1:0]                capCsDpl, capSsDpl;
  logic [NUM_DATA*SEL_W-1:0] capDataSel;
  logic [NUM_DATA-1:0]       capDValid, capDRead, capDPres, capDConf;
  logic [2*NUM_DATA-1:0]     capDDpl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capTssSel <= '0; capCsSel <= '0; capSsSel <= '0;
      capTssPresent <= 1'b0; capTssBusy <= 1'b0; capLimit <= '0;
      capLdtValid <= 1'b0; capLdtPresent <= 1'b0;
      capCsValid <= 1'b0; capCsPresent <= 1'b0; capCsDpl <= '0;
      capSsValid <= 1'b0; capSsPresent <= 1'b0; capSsDpl <= '0;
      capDataSel <= '0; capDValid <= '0; capDRead <= '0;
      capDPres <= '0; capDConf <= '0; capDDpl <= '0;
    end else if (strobe.capture) begin
      capTssSel <= tssSel; capCsSel <= csSel; capSsSel <= ssSel;
      capTssPresent <= tssPresent; capTssBusy <= tssBusy; capLimit <= tssLimit;
      capLdtValid <= ldtSelValid; capLdtPresent <= ldtPresent;
      capCsValid <= csSelValid; capCsPresent <= csPresent; capCsDpl <= csDpl;
      capSsValid <= ssSelValid; capSsPresent <= ssPresent; capSsDpl <= ssDpl;
      capDataSel <= dataSel; capDValid <= dataSelValid; capDRead <= dataReadable;
      capDPres <= dataPresent; capDConf <= dataConforming; capDDpl <= dataDpl;
    end
  end

  logic [1:0] cpl;
  assign cpl = capCsSel[1:0];

  // Per-lane failure vectors for the four data segment tests
  logic [NUM_DATA-1:0] badValid, badRead, badPres, badDpl;
  for (genvar g = 0; g < NUM_DATA; g++) begin : g_lane
    logic isNull;
    assign isNull      = ~|capDataSel[g*SEL_W+2 +: SEL_W-2];
    assign badValid[g] = ~isNull & ~capDValid[g];
    assign badRead[g]  = ~isNull & ~capDRead[g];
    assign badPres[g]  = ~isNull & ~capDPres[g];
    assign badDpl[g]   = ~isNull & ~capDConf[g] & (capDDpl[2*g +: 2] < cpl);
  end

  function automatic logic [DIDX_W-1:0] lowestSet(input logic [NUM_DATA-1:0] v);
    lowestSet = '0;
    for (int i = NUM_DATA - 1; i >= 0; i--) begin
      if (v[i]) lowestSet = DIDX_W'(i);
    end
  endfunction

  logic [4:0]          checkNum;
  logic [NUM_DATA-1:0] laneVec;
  logic [DIDX_W-1:0]   laneIdx;
  logic [1:0]          curClass;
  logic [SEL_W-1:0]    curSel;

  always_comb begin
    if (strobe.stage < STAGE_W'(LOAD_STAGE))       checkNum = 5'(strobe.stage) + 5'd1;
    else if (strobe.stage == STAGE_W'(LOAD_STAGE)) checkNum = 5'd0;
    else                                           checkNum = 5'(strobe.stage);
  end

  always_comb begin
    laneVec = '0;
    unique case (checkNum)
      5'd13:   laneVec = badValid;
      5'd14:   laneVec = badRead;
      5'd15:   laneVec = badPres;
      5'd16:   laneVec = badDpl;
      default: laneVec = '0;
    endcase
  end
  assign laneIdx = lowestSet(laneVec);

  always_comb begin
    checkFail = 1'b0;
    curClass  = FC_GEN_PROT;
    curSel    = capTssSel;
    case (checkNum)
      5'd1:  begin checkFail = ~capTssPresent; curClass = FC_NOT_PRESENT; end
      5'd2:  begin checkFail = capTssBusy;     curClass = FC_GEN_PROT;    end
      5'd3:  begin checkFail = capLimit < LIMIT_W'(MIN_TSS_LIMIT); curClass = FC_BAD_TSS; end
      5'd4:  begin checkFail = ~capLdtValid;   curClass = FC_BAD_TSS;     end
      5'd5:  begin checkFail = ~capLdtPresent; curClass = FC_BAD_TSS;     end
      5'd6:  begin checkFail = ~capCsValid;    curClass = FC_BAD_TSS;     curSel = capCsSel; end
      5'd7:  begin checkFail = ~capCsPresent;  curClass = FC_NOT_PRESENT; curSel = capCsSel; end
      5'd8:  begin checkFail = capCsDpl != cpl; curClass = FC_BAD_TSS;    curSel = capCsSel; end
      5'd9:  begin checkFail = ~capSsValid;    curClass = FC_GEN_PROT;    curSel = capSsSel; end
      5'd10: begin checkFail = ~capSsPresent;  curClass = FC_STACK;       curSel = capSsSel; end
      5'd11: begin checkFail = capSsDpl != cpl; curClass = FC_STACK;      curSel = capSsSel; end
      5'd12: begin checkFail = capSsSel[1:0] != cpl; curClass = FC_GEN_PROT; curSel = capSsSel; end
      5'd13, 5'd14, 5'd16: begin
        checkFail = |laneVec; curClass = FC_GEN_PROT;
        curSel = capDataSel[laneIdx*SEL_W +: SEL_W];
      end
      5'd15: begin
        checkFail = |laneVec; curClass = FC_NOT_PRESENT;
        curSel = capDataSel[laneIdx*SEL_W +: SEL_W];
      end
      default: checkFail = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultClass <= '0;
      errSel     <= '0;
      newCpl     <= '0;
    end else if (strobe.report) begin
      if (checkFail) begin
        faultClass <= curClass;
        errSel     <= curSel;
      end else begin
        newCpl <= cpl;
      end
    end
  end
endmodule

// File: rtl/tsv_top.sv
module tsv_top
  import tsv_pkg::*;
#(
  parameter int SEL_W         = 16,
  parameter int LIMIT_W       = 32,
  parameter int MIN_TSS_LIMIT = 103,
  parameter int NUM_DATA      = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [SEL_W-1:0]          tssSel,
  input  logic                      tssPresent,
  input  logic                      tssBusy,
  input  logic [LIMIT_W-1:0]        tssLimit,
  input  logic                      ldtSelValid,
  input  logic                      ldtPresent,
  input  logic [SEL_W-1:0]          csSel,
  input  logic                      csSelValid,
  input  logic                      csPresent,
  input  logic [1:0]                csDpl,
  input  logic [SEL_W-1:0]          ssSel,
  input  logic                      ssSelValid,
  input  logic                      ssPresent,
  input  logic [1:0]                ssDpl,
  input  logic [NUM_DATA*SEL_W-1:0] dataSel,
  input  logic [NUM_DATA-1:0]       dataSelValid,
  input  logic [NUM_DATA-1:0]       dataReadable,
  input  logic [NUM_DATA-1:0]       dataPresent,
  input  logic [NUM_DATA-1:0]       dataConforming,
  input  logic [2*NUM_DATA-1:0]     dataDpl,
  output logic                      busy,
  output logic                      done,
  output logic                      pass,
  output logic                      fault,
  output logic [1:0]                faultClass,
  output logic [SEL_W-1:0]          errSel,
  output logic [1:0]                newCpl,
  output logic                      setTaskSwitched
);
  tsvStrobe_t strobe;
  logic       checkFail;

  tsv_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .checkFail(checkFail),
    .strobe(strobe), .busy(busy), .done(done), .pass(pass),
    .fault(fault), .setTaskSwitched(setTaskSwitched)
  );

  tsv_dpath #(
    .SEL_W(SEL_W), .LIMIT_W(LIMIT_W),
    .MIN_TSS_LIMIT(MIN_TSS_LIMIT), .NUM_DATA(NUM_DATA)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .tssSel(tssSel), .tssPresent(tssPresent), .tssBusy(tssBusy), .tssLimit(tssLimit),
    .ldtSelValid(ldtSelValid), .ldtPresent(ldtPresent),
    .csSel(csSel), .csSelValid(csSelValid), .csPresent(csPresent), .csDpl(csDpl),
    .ssSel(ssSel), .ssSelValid(ssSelValid), .ssPresent(ssPresent), .ssDpl(ssDpl),
    .dataSel(dataSel), .dataSelValid(dataSelValid), .dataReadable(dataReadable),
    .dataPresent(dataPresent), .dataConforming(dataConforming), .dataDpl(dataDpl),
    .checkFail(checkFail), .faultClass(faultClass), .errSel(errSel), .newCpl(newCpl)
  );
endmodule

// File: rtl/tsv_checker.sv
module tsv_checker
  import tsv_pkg::*;
#(
  parameter int SEL_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             pass,
  input logic             fault,
  input logic             setTaskSwitched,
  input logic [SEL_W-1:0] csSel,
  input logic [1:0]       newCpl
);
  logic [5:0] runCycles;
  logic [1:0] cplCap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCycles <= '0;
      cplCap    <= '0;
    end else if (start && !busy) begin
      runCycles <= '0;
      cplCap    <= csSel[1:0];
    end else if (busy) begin
      runCycles <= runCycles + 1'b1;
    end
  end

  p_pass_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    done && pass |-> runCycles == 6'(NUM_STAGES));

  p_cpl_from_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    done && pass |-> newCpl == cplCap);

  p_flag_only_on_pass_r9: assert property (@(posedge clk) disable iff (!rstN)
    setTaskSwitched |-> done && pass);

  p_busy_needs_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  p_idle_at_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_one_result_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (pass ^ fault));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_no_stray_result_r12: assert property (@(posedge clk) disable iff (!rstN)
    (pass || fault) |-> done);
endmodule

bind tsv_top tsv_checker #(.SEL_W(SEL_W)) i_tsvChecker (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .pass(pass), .fault(fault), .setTaskSwitched(setTaskSwitched),
  .csSel(csSel), .newCpl(newCpl)
);

// File: tb/test_tsv_top.sv
module test_tsv_top;
  localparam int MIN_LIM = 103;
  localparam int NVEC = 17;
  // {breakTest[4:0], lane[1:0], expClass[1:0]}; breakTest 0 means no fault
  localparam logic [8:0] VEC [NVEC] = '{
    {5'd0, 2'd0, 2'd0},  {5'd1, 2'd0, 2'd0},  {5'd2, 2'd0, 2'd1},
    {5'd3, 2'd0, 2'd2},  {5'd4, 2'd0, 2'd2},  {5'd5, 2'd0, 2'd2},
    {5'd6, 2'd0, 2'd2},  {5'd7, 2'd0, 2'd0},  {5'd8, 2'd0, 2'd2},
    {5'd9, 2'd0, 2'd1},  {5'd10, 2'd0, 2'd3}, {5'd11, 2'd0, 2'd3},
    {5'd12, 2'd0, 2'd1}, {5'd13, 2'd0, 2'd1}, {5'd14, 2'd1, 2'd1},
    {5'd15, 2'd2, 2'd0}, {5'd16, 2'd3, 2'd1}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [15:0] tssSel, csSel, ssSel;
  logic tssPresent, tssBusy, ldtSelValid, ldtPresent;
  logic [31:0] tssLimit;
  logic csSelValid, csPresent, ssSelValid, ssPresent;
  logic [1:0] csDpl, ssDpl;
  logic [63:0] dataSel;
  logic [3:0] dataSelValid, dataReadable, dataPresent, dataConforming;
  logic [7:0] dataDpl;
  logic busy, done, pass, fault, setTaskSwitched;
  logic [1:0] faultClass, newCpl;
  logic [15:0] errSel;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  tsv_top i_tsv_top (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic setGood();
    tssSel = 16'h0048; tssPresent = 1; tssBusy = 0; tssLimit = 32'd200;
    ldtSelValid = 1; ldtPresent = 1;
    csSel = 16'h0012; csSelValid = 1; csPresent = 1; csDpl = 2'd2;
    ssSel = 16'h0022; ssSelValid = 1; ssPresent = 1; ssDpl = 2'd2;
    for (int i = 0; i < 4; i++) dataSel[16*i +: 16] = 16'h0030 + 16'(8*i);
    dataSelValid = 4'hF; dataReadable = 4'hF; dataPresent = 4'hF;
    dataConforming = 4'h0; dataDpl = 8'hFF;
  endtask

  task automatic applyBreak(input int t, input int ln);
    case (t)
      1: tssPresent = 0;
      2: tssBusy = 1;
      3: tssLimit = 32'(MIN_LIM - 1);
      4: ldtSelValid = 0;
      5: ldtPresent = 0;
      6: csSelValid = 0;
      7: csPresent = 0;
      8: csDpl = 2'd1;
      9: ssSelValid = 0;
      10: ssPresent = 0;
      11: ssDpl = 2'd3;
      12: ssSel = 16'h0021;
      13: dataSelValid[ln] = 0;
      14: dataReadable[ln] = 0;
      15: dataPresent[ln] = 0;
      16: dataDpl[2*ln +: 2] = 2'd1;
      default: ;
    endcase
  endtask

  function automatic logic [15:0] selFor(input int t, input int ln);
    if (t <= 5) return tssSel;
    if (t <= 8) return csSel;
    if (t <= 12) return ssSel;
    return dataSel[16*ln +: 16];
  endfunction

  // Pulse start, then count clocks until done; returns latency (99 on timeout)
  task automatic launch(output int lat);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
    lat = 99;
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      if (done) begin lat = n; break; end
    end
  endtask

  task automatic runCase(input string req, input bit expPass, input int expLat,
                         input logic [1:0] expCls, input logic [15:0] expSel,
                         input logic [1:0] expCpl);
    int lat;
    launch(lat);
    chk(lat == expLat, "R1", {req, " done latency"}, lat, expLat);
    chk(pass == expPass && fault == !expPass, "R12", {req, " pass/fault"}, {pass, fault}, {expPass, !expPass});
    chk(setTaskSwitched == expPass, "R9", {req, " task-switched pulse"}, setTaskSwitched, expPass);
    if (expPass) begin
      chk(newCpl == expCpl, "R9", {req, " newCpl"}, newCpl, expCpl);
    end else begin
      chk(faultClass == expCls, req, "class", faultClass, expCls);
      chk(errSel == expSel, req, "error selector", errSel, expSel);
    end
    @(negedge clk);
    chk(!done && !setTaskSwitched, "R12", {req, " done one clock"}, {done, setTaskSwitched}, 0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    setGood();
    repeat (3) @(negedge clk);
    // R11: reset state
    chk({busy, done, pass, fault, setTaskSwitched} == 5'b0, "R11", "outputs in reset",
        {busy, done, pass, fault, setTaskSwitched}, 0);
    rstN = 1;
    @(negedge clk);
    chk({busy, done, pass, fault, setTaskSwitched} == 5'b0, "R11", "outputs after reset",
        {busy, done, pass, fault, setTaskSwitched}, 0);

    // Table walk: each test broken alone (R2 to R6 per group, R8 class encoding)
    for (int v = 0; v < NVEC; v++) begin
      int t, ln, lat;
      string req;
      t = int'(VEC[v][8:4]); ln = int'(VEC[v][3:2]);
      req = (t == 0) ? "R9" : (t <= 3) ? "R2" : (t <= 5) ? "R3" :
            (t <= 8) ? "R4" : (t <= 12) ? "R5" : "R6";
      setGood();
      applyBreak(t, ln);
      lat = (t == 0) ? 17 : (t <= 3) ? t : t + 1;
      runCase(req, t == 0, lat, VEC[v][1:0], selFor(t, ln), 2'd2);
    end

    // R2: limit exactly at the minimum passes
    setGood(); tssLimit = 32'(MIN_LIM);
    runCase("R2", 1, 17, 0, 0, 2'd2);

    // R8: two faults, the earlier test (7, code not present) wins over test 10
    setGood(); csPresent = 0; ssPresent = 0;
    runCase("R8", 0, 8, 2'd0, csSel, 0);

    // R6: ES invalid (test 13) beats DS absent (test 15)
    setGood(); dataSelValid[1] = 0; dataPresent[0] = 0;
    runCase("R6", 0, 14, 2'd1, dataSel[31:16], 0);

    // R6: FS and GS both invalid, lower lane FS reported
    setGood(); dataSelValid[2] = 0; dataSelValid[3] = 0;
    runCase("R6", 0, 14, 2'd1, dataSel[47:32], 0);

    // R7: null ES selector with every attribute bad still passes
    setGood(); dataSel[31:16] = 16'h0003;
    dataSelValid[1] = 0; dataReadable[1] = 0; dataPresent[1] = 0; dataDpl[3:2] = 0;
    runCase("R7", 1, 17, 0, 0, 2'd2);

    // R7: conforming FS with DPL 0 is exempt from test 16
    setGood(); dataConforming[2] = 1; dataDpl[5:4] = 2'd0;
    runCase("R7", 1, 17, 0, 0, 2'd2);

    // R9: new CPL follows the code selector RPL (3)
    setGood(); csSel = 16'h0013; csDpl = 2'd3; ssSel = 16'h0023; ssDpl = 2'd3;
    runCase("R9", 1, 17, 0, 0, 2'd3);

    // R10: start while busy with a broken snapshot is ignored
    begin
      int lat;
      setGood();
      @(negedge clk) start = 1;
      @(negedge clk) start = 0;
      lat = 99;
      for (int n = 1; n <= 40; n++) begin
        if (n == 5) begin tssPresent = 0; csSel = 16'h0011; start = 1; end
        else start = 0;
        @(negedge clk);
        if (done) begin lat = n; break; end
      end
      start = 0;
      chk(lat == 17, "R10", "latency with ignored start", lat, 17);
      chk(pass == 1 && fault == 0, "R10", "result with ignored start", {pass, fault}, 2'b10);
      chk(newCpl == 2'd2, "R10", "captured cpl", newCpl, 2);
      begin
        int extra = 0;
        for (int n = 0; n < 20; n++) begin
          @(negedge clk);
          if (done || busy) extra++;
        end
        chk(extra == 0, "R10", "no queued run", extra, 0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule